// File: doc/BRIEF.md
# NAND Sector Hamming Syndrome Corrector

This block checks one 512-byte NAND sector that is protected by a 3-byte Hamming code and repairs it in place. After a sector has been read into a local sector buffer, the controller presents two codes together with a single start pulse. One code is the value recovered from the spare area. The other is the value computed over the data just read. The block expands each code into a 32-bit parity word, XORs the two words into a syndrome, and counts the set bits of the syndrome. The count decides the outcome: a clean sector, a single flipped data bit, a damaged stored code, or a sector that cannot be repaired.

A single data-bit error is fixed by the block itself. It takes the single-port byte port of the sector buffer, reads the faulty byte, inverts one bit, and writes the byte back. It then gives the port back to its owner. A blank (erased) sector has an all-ones stored code and an all-zero computed code. This case is accepted as clean even though its syndrome weight would otherwise be uncorrectable.

Top module: `hamming_sector_fixer`

## Requirements
- R1: After reset the block is idle: `done_o` is low, `status_o` is 0, and `buf_req_o` and `buf_we_o` are low.
- R2: Each 24-bit code input is the byte triple {b2,b1,b0} in bits [23:16],[15:8],[7:0]. It expands into a 32-bit word in this layout: b0 in bits 7:0, the low nibble of b2 in bits 11:8, b1 in bits 23:16, the high nibble of b2 in bits 27:24, and all other bits zero.
- R3: Equal codes give status 0 (ok). In that case `done_o` pulses for one cycle, two rising edges after the edge that samples `start_i`. The buffer port is not touched.
- R4: A syndrome with exactly 12 set bits gives status 1 (corrected). Syndrome bits 18:16 give the bit index, shown on `fix_bit_o`. Syndrome bits 27:19 give the byte index, shown on `fix_byte_o`. Only that bit of that buffer byte is inverted, and no other byte changes.
- R5: A syndrome with exactly one set bit gives status 2 (stored code bad). The buffer is not accessed.
- R6: Any other nonzero syndrome gives status 3 (uncorrectable). The buffer is not accessed.
- R7: There is one exception to R6. An expanded stored word of 0x0FFF0FFF with an expanded computed word of 0x00000000 gives status 0. The reverse pairing is still uncorrectable.
- R8: The correction is a read of the addressed byte followed by a write of that byte XOR a one-hot mask. `done_o` pulses one cycle after the write cycle, which is five edges after start is sampled. A read issued in one cycle returns its data in the next cycle.
- R9: A start pulse arriving while an operation is in progress is ignored and produces no extra `done_o`.
- R10: `buf_req_o` is low whenever `done_o` is high and whenever the block is idle. The port belongs to the external owner at those times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; codes sampled with it |
| stored_code_i | input | 24 | Code read from the spare area, {b2,b1,b0} |
| calc_code_i | input | 24 | Code computed over the read data, {b2,b1,b0} |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 2 | 0 ok, 1 corrected, 2 stored code bad, 3 uncorrectable |
| fix_byte_o | output | 9 | Byte index decoded from the syndrome |
| fix_bit_o | output | 3 | Bit index decoded from the syndrome |
| buf_req_o | output | 1 | Block owns the sector buffer port |
| buf_addr_o | output | 9 | Sector buffer byte address |
| buf_we_o | output | 1 | Sector buffer write enable |
| buf_wdata_o | output | 8 | Sector buffer write data |
| buf_rdata_i | input | 8 | Sector buffer read data, valid one cycle after the address |

## Verification
The assertions check the buffer-port protocol on every cycle:
- `done_o` is a single-cycle pulse.
- A write only occurs while the port is held.
- The address stays stable during the whole access.
- Each written byte differs in exactly one bit from the byte read just before it.
- The port is free when `done_o` is high.
- A corrected status always follows a write, and every other status follows a run with no buffer access.

Only the bench scenarios can show the rest:
- The nibble-level unpacking.
- Which byte and bit the syndrome names.
- The weight-based classes, including the one-directional erased exception.
- The latencies.
- That the rest of the sector is left intact.
- That a restart during a correction is ignored.

// File: rtl/hsf_pkg.sv
package hsf_pkg;
   localparam int unsigned CODE_W      = 24;
   localparam int unsigned WORD_W      = 32;
   localparam int unsigned LOC_LSB     = 16;
   localparam int unsigned LOC_W       = 12;
   localparam int unsigned FIX_WEIGHT  = CODE_W / 2;
   localparam logic [WORD_W-1:0] BLANK_STORED = 32'h0FFF_0FFF;

   typedef enum logic [1:0] {
      HSF_OK       = 2'd0,
      HSF_FIXED    = 2'd1,
      HSF_CODE_BAD = 2'd2,
      HSF_UNCORR   = 2'd3
   } hsf_status_e;

   typedef enum logic [1:0] {
      TOP_IDLE,
      TOP_EVAL,
      TOP_FIXING,
      TOP_FIN
   } hsf_top_state_e;

   typedef enum logic [1:0] {
      RMW_IDLE,
      RMW_RD,
      RMW_MOD,
      RMW_WR
   } hsf_rmw_state_e;
endpackage

// File: rtl/hsf_unpack.sv
module hsf_unpack
   import hsf_pkg::*;
(
   input  logic [CODE_W-1:0] code_i,
   output logic [WORD_W-1:0] word_o
);
   logic [7:0] b0, b1, b2;

   assign b0 = code_i[7:0];
   assign b1 = code_i[15:8];
   assign b2 = code_i[23:16];

   // Byte 2 is split: high nibble above b1, low nibble above b0.
   assign word_o = {4'h0, b2[7:4], b1, 4'h0, b2[3:0], b0};
endmodule

// File: rtl/hsf_popcount.sv
module hsf_popcount #(
   parameter int unsigned W   = 24,
   parameter int unsigned GRP = 4,
   localparam int unsigned NG  = W / GRP,
   localparam int unsigned GW  = $clog2(GRP + 1),
   localparam int unsigned CW  = $clog2(W + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [W-1:0]  vec_i,
   output logic [CW-1:0] cnt_o
);
   if (W % GRP != 0) begin : g_bad_grp
      $error("hsf_popcount: W must be a multiple of GRP");
   end

   function automatic logic [GW-1:0] slice_count(input logic [GRP-1:0] s);
      logic [GW-1:0] acc;
      acc = '0;
      for (int k = 0; k < GRP; k++) acc = acc + GW'(s[k]);
      return acc;
   endfunction

   logic [NG*GW-1:0] parts;
   logic [CW-1:0]    total;

   for (genvar g = 0; g < NG; g++) begin : g_leaf
      assign parts[g*GW +: GW] = slice_count(vec_i[g*GRP +: GRP]);
   end

   always_comb begin
      total = '0;
      for (int g = 0; g < NG; g++) total = total + CW'(parts[g*GW +: GW]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_o <= '0;
      else if (load_i) cnt_o <= total;
   end
endmodule

// File: rtl/hsf_rmw.sv
module hsf_rmw
   import hsf_pkg::*;
#(
   parameter int unsigned ADDR_W = 9,
   parameter int unsigned BYTE_W = 8,
   localparam int unsigned BIT_W = $clog2(BYTE_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              kick_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [BIT_W-1:0]  bit_i,
   input  logic [BYTE_W-1:0] rdata_i,
   output logic              req_o,
   output logic              we_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [BYTE_W-1:0] wdata_o,
   output logic              done_o
);
   hsf_rmw_state_e state_q;
   logic [BYTE_W-1:0] mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= RMW_IDLE;
         addr_o  <= '0;
         mask_q  <= '0;
         wdata_o <= '0;
      end else begin
         unique case (state_q)
            RMW_IDLE: if (kick_i) begin
               state_q <= RMW_RD;
               addr_o  <= addr_i;
               mask_q  <= BYTE_W'(1) << bit_i;
            end
            RMW_RD:  state_q <= RMW_MOD;
            RMW_MOD: begin
               wdata_o <= rdata_i ^ mask_q;
               state_q <= RMW_WR;
            end
            RMW_WR:  state_q <= RMW_IDLE;
            default: state_q <= RMW_IDLE;
         endcase
      end
   end

   assign req_o  = (state_q != RMW_IDLE);
   assign we_o   = (state_q == RMW_WR);
   assign done_o = (state_q == RMW_WR);
endmodule

// File: rtl/hamming_sector_fixer.sv
module hamming_sector_fixer
   import hsf_pkg::*;
#(
   parameter int unsigned SECTOR_BYTES = 512,
   parameter int unsigned BYTE_W       = 8,
   parameter int unsigned POP_GRP      = 4,
   localparam int unsigned ADDR_W = $clog2(SECTOR_BYTES),
   localparam int unsigned BIT_W  = $clog2(BYTE_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [CODE_W-1:0] stored_code_i,
   input  logic [CODE_W-1:0] calc_code_i,
   output logic              done_o,
   output logic [1:0]        status_o,
   output logic [ADDR_W-1:0] fix_byte_o,
   output logic [BIT_W-1:0]  fix_bit_o,
   output logic              buf_req_o,
   output logic [ADDR_W-1:0] buf_addr_o,
   output logic              buf_we_o,
   output logic [BYTE_W-1:0] buf_wdata_o,
   input  logic [BYTE_W-1:0] buf_rdata_i
);
   localparam int unsigned CW = $clog2(CODE_W + 1);

   if (ADDR_W + BIT_W != LOC_W) begin : g_bad_geom
      $error("hamming_sector_fixer: sector geometry must match 12-bit location field");
   end
   if ((1 << BIT_W) != BYTE_W) begin : g_bad_byte
      $error("hamming_sector_fixer: BYTE_W must be a power of two");
   end

   logic [WORD_W-1:0] st_word, ca_word;
   logic [LOC_W-1:0]  syn_hi, syn_lo;
   logic [CW-1:0]     pop_cnt;
   logic [LOC_W-1:0]  loc_q;
   logic              blank_q;
   hsf_top_state_e    state_q;
   hsf_status_e       cls, status_q;
   logic              accept, kick, rmw_done;

   hsf_unpack u_unp_st (.code_i(stored_code_i), .word_o(st_word));
   hsf_unpack u_unp_ca (.code_i(calc_code_i),   .word_o(ca_word));

   assign syn_hi = st_word[LOC_LSB +: LOC_W] ^ ca_word[LOC_LSB +: LOC_W];
   assign syn_lo = st_word[LOC_W-1:0]        ^ ca_word[LOC_W-1:0];
   assign accept = start_i && (state_q == TOP_IDLE);

   hsf_popcount #(.W(CODE_W), .GRP(POP_GRP)) u_pop (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (accept),
      .vec_i  ({syn_hi, syn_lo}),
      .cnt_o  (pop_cnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         loc_q   <= '0;
         blank_q <= 1'b0;
      end else if (accept) begin
         loc_q   <= syn_hi;
         blank_q <= (st_word == BLANK_STORED) && (ca_word == '0);
      end
   end

   always_comb begin
      if (pop_cnt == '0)                   cls = HSF_OK;
      else if (pop_cnt == CW'(FIX_WEIGHT)) cls = HSF_FIXED;
      else if (pop_cnt == CW'(1))          cls = HSF_CODE_BAD;
      else if (blank_q)                    cls = HSF_OK;
      else                                 cls = HSF_UNCORR;
   end

   assign kick = (state_q == TOP_EVAL) && (cls == HSF_FIXED);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= TOP_IDLE;
         status_q <= HSF_OK;
      end else begin
         unique case (state_q)
            TOP_IDLE:   if (accept) state_q <= TOP_EVAL;
            TOP_EVAL: begin
               status_q <= cls;
               state_q  <= kick ? TOP_FIXING : TOP_FIN;
            end
            TOP_FIXING: if (rmw_done) state_q <= TOP_FIN;
            TOP_FIN:    state_q <= TOP_IDLE;
            default:    state_q <= TOP_IDLE;
         endcase
      end
   end

   hsf_rmw #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_rmw (
      .clk     (clk),
      .rst_n   (rst_n),
      .kick_i  (kick),
      .addr_i  (loc_q[LOC_W-1:BIT_W]),
      .bit_i   (loc_q[BIT_W-1:0]),
      .rdata_i (buf_rdata_i),
      .req_o   (buf_req_o),
      .we_o    (buf_we_o),
      .addr_o  (buf_addr_o),
      .wdata_o (buf_wdata_o),
      .done_o  (rmw_done)
   );

   assign done_o     = (state_q == TOP_FIN);
   assign status_o   = status_q;
   assign fix_byte_o = loc_q[LOC_W-1:BIT_W];
   assign fix_bit_o  = loc_q[BIT_W-1:0];
endmodule

// File: rtl/hsf_checker.sv
module hsf_checker #(
   parameter int unsigned ADDR_W = 9,
   parameter int unsigned BYTE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              done_o,
   input logic [1:0]        status_o,
   input logic              buf_req_o,
   input logic              buf_we_o,
   input logic [ADDR_W-1:0] buf_addr_o,
   input logic [BYTE_W-1:0] buf_wdata_o,
   input logic [BYTE_W-1:0] buf_rdata_i
);
   // R3: completion is a single-cycle pulse
   a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R8: writes only while the port is held
   a_r8_we_in_req: assert property (@(posedge clk) disable iff (!rst_n)
      buf_we_o |-> buf_req_o);

   // R8: address held steady across the access
   a_r8_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_req_o && $past(buf_req_o)) |-> $stable(buf_addr_o));

   // R8: written byte differs from the byte read in exactly one bit
   a_r8_single_flip: assert property (@(posedge clk) disable iff (!rst_n)
      buf_we_o |-> ($countones(buf_wdata_o ^ $past(buf_rdata_i)) == 1));

   // R10: port released while done is shown
   a_r10_released: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !buf_req_o);

   // R4: corrected status comes right after the write-back
   a_r4_fix_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && status_o == 2'd1) |-> $past(buf_we_o));

   // R5: R6: other statuses never follow a buffer access
   a_r6_no_access: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && status_o != 2'd1) |-> !$past(buf_req_o));
endmodule

bind hamming_sector_fixer hsf_checker #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_hsf_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .done_o      (done_o),
   .status_o    (status_o),
   .buf_req_o   (buf_req_o),
   .buf_we_o    (buf_we_o),
   .buf_addr_o  (buf_addr_o),
   .buf_wdata_o (buf_wdata_o),
   .buf_rdata_i (buf_rdata_i)
);

// File: tb/tb_hamming_sector_fixer.sv
`timescale 1ns/100ps
module tb_hamming_sector_fixer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [23:0] stored_code_i = '0;
   logic [23:0] calc_code_i = '0;
   logic        done_o;
   logic [1:0]  status_o;
   logic [8:0]  fix_byte_o;
   logic [2:0]  fix_bit_o;
   logic        buf_req_o;
   logic [8:0]  buf_addr_o;
   logic        buf_we_o;
   logic [7:0]  buf_wdata_o;
   logic [7:0]  buf_rdata_i = '0;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   int dones = 0;
   int runs = 0;
   bit req_seen = 1'b0;
   bit finished = 1'b0;

   logic [7:0] mem    [512];
   logic [7:0] shadow [512];

   typedef struct {
      logic [1:0] st;
      logic [8:0] by;
      logic [2:0] bi;
      int         lat;
      bit         fix;
      int         t0;
      string      req;
   } item_t;
   item_t sb[$];

   always #2.5 clk = ~clk;

   hamming_sector_fixer dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .stored_code_i(stored_code_i), .calc_code_i(calc_code_i),
      .done_o(done_o), .status_o(status_o),
      .fix_byte_o(fix_byte_o), .fix_bit_o(fix_bit_o),
      .buf_req_o(buf_req_o), .buf_addr_o(buf_addr_o), .buf_we_o(buf_we_o),
      .buf_wdata_o(buf_wdata_o), .buf_rdata_i(buf_rdata_i)
   );

   // synchronous single-port sector buffer model
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (buf_req_o && buf_we_o) mem[buf_addr_o] <= buf_wdata_o;
      buf_rdata_i <= mem[buf_addr_o];
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [23:0] pack(input logic [31:0] w);
      return {w[27:24], w[11:8], w[23:16], w[7:0]};
   endfunction

   function automatic logic [31:0] fix_syndrome(input logic [8:0] by, input logic [2:0] bi);
      logic [11:0] loc;
      loc = {by, bi};
      return {4'h0, loc, 4'h0, ~loc};
   endfunction

   // monitor: pops expected results as completions appear
   always @(negedge clk) begin
      if (rst_n && buf_req_o) req_seen = 1'b1;
      if (rst_n && done_o) begin
         item_t it;
         dones++;
         chk(!buf_req_o, "R10 port released at done", int'(buf_req_o), 0);
         if (sb.size() == 0) begin
            chk(1'b0, "R9 unexpected done", 1, 0);
         end else begin
            it = sb.pop_front();
            chk(status_o == it.st, {it.req, " status"}, int'(status_o), int'(it.st));
            chk(cyc - it.t0 == it.lat, {it.req, " latency"}, cyc - it.t0, it.lat);
            if (it.fix) begin
               chk(fix_byte_o == it.by, {it.req, " byte index"}, int'(fix_byte_o), int'(it.by));
               chk(fix_bit_o == it.bi, {it.req, " bit index"}, int'(fix_bit_o), int'(it.bi));
               chk(mem[it.by] == shadow[it.by], {it.req, " flipped byte"}, int'(mem[it.by]), int'(shadow[it.by]));
            end else begin
               chk(!req_seen, {it.req, " no buffer access"}, int'(req_seen), 0);
            end
         end
      end
   end

   task automatic run(input logic [23:0] sc, input logic [23:0] cc, input logic [1:0] st,
                      input logic [8:0] by, input logic [2:0] bi, input bit fix,
                      input bit poke, input string req);
      item_t it;
      @(negedge clk);
      it.st = st; it.by = by; it.bi = bi; it.fix = fix;
      it.lat = fix ? 5 : 2; it.t0 = cyc; it.req = req;
      if (fix) shadow[by] = shadow[by] ^ (8'd1 << bi);
      sb.push_back(it);
      runs++;
      req_seen = 1'b0;
      start_i = 1'b1; stored_code_i = sc; calc_code_i = cc;
      @(negedge clk);
      start_i = 1'b0;
      if (poke) begin
         // R9: restart with a code-bad pattern while busy
         @(negedge clk);
         start_i = 1'b1; stored_code_i = 24'h000000; calc_code_i = 24'h000001;
         @(negedge clk);
         start_i = 1'b0;
      end
      while (sb.size() != 0) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      for (int i = 0; i < 512; i++) begin
         mem[i] = 8'((i * 37 + 5) & 8'hFF);
         shadow[i] = mem[i];
      end
      repeat (3) @(negedge clk);
      // R1: idle state under and after reset
      chk(!done_o && status_o == 2'd0, "R1 reset outputs", {30'd0, status_o} | (int'(done_o) << 4), 0);
      chk(!buf_req_o && !buf_we_o, "R1 reset buffer port", int'(buf_req_o), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!done_o && !buf_req_o, "R1 idle after reset", int'(done_o), 0);

      // R3: equal codes
      run(24'h5A3C96, 24'h5A3C96, 2'd0, '0, '0, 0, 0, "R3 clean");
      run(24'hFFFFFF, 24'hFFFFFF, 2'd0, '0, '0, 0, 0, "R3 clean ones");
      // R4: R8: single data-bit errors at edges and middle
      run(24'h123456 ^ pack(fix_syndrome(9'd0, 3'd0)), 24'h123456, 2'd1, 9'd0, 3'd0, 1, 0, "R4 fix byte0 bit0");
      run(24'hA5A5A5 ^ pack(fix_syndrome(9'd511, 3'd7)), 24'hA5A5A5, 2'd1, 9'd511, 3'd7, 1, 0, "R4 fix byte511 bit7");
      run(24'h0F0F0F ^ pack(fix_syndrome(9'd300, 3'd3)), 24'h0F0F0F, 2'd1, 9'd300, 3'd3, 1, 0, "R8 fix byte300 bit3");
      // R2: a single bit in b2's low nibble lands in word bit 9
      run(24'h777777 ^ 24'h020000, 24'h777777, 2'd2, '0, '0, 0, 0, "R5 R2 code bit b2 low");
      run(24'h777777 ^ 24'h800000, 24'h777777, 2'd2, '0, '0, 0, 0, "R5 R2 code bit b2 high");
      // R6: other weights
      run(24'h000003, 24'h000000, 2'd3, '0, '0, 0, 0, "R6 weight two");
      run(24'hFFFFFE, 24'h000000, 2'd3, '0, '0, 0, 0, "R6 weight 23");
      // R2: weight-12 pattern that does not use the location field layout still decodes
      run(pack({4'h0, 12'hFFF, 16'h0000}), 24'h000000, 2'd1, 9'd511, 3'd7, 1, 0, "R2 R4 high field only");
      // R7: blank sector exception, and its reverse
      run(24'hFFFFFF, 24'h000000, 2'd0, '0, '0, 0, 0, "R7 erased");
      run(24'h000000, 24'hFFFFFF, 2'd3, '0, '0, 0, 0, "R7 reverse not erased");
      // R9: restart during a correction is ignored
      run(24'h3C3C3C ^ pack(fix_syndrome(9'd77, 3'd5)), 24'h3C3C3C, 2'd1, 9'd77, 3'd5, 1, 1, "R9 busy fix");
      repeat (6) @(negedge clk);
      chk(dones == runs, "R9 done count", dones, runs);

      begin
         int bad;
         bad = -1;
         for (int i = 0; i < 512; i++) if (mem[i] !== shadow[i] && bad < 0) bad = i;
         chk(bad < 0, "R4 sector image intact", bad, -1);
      end
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         chk(1'b0, "watchdog expired", cyc, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule